// File: doc/BRIEF.md
# Torus Dimension-Order Wormhole Router

This block is one node of a two-dimensional torus on-chip network. Links between neighbouring nodes are unidirectional. Each link carries 16-bit flits with a two-bit kind code and a one-bit virtual-channel tag, under a valid/ready handshake that has one ready bit per virtual channel. The node has three inputs and three outputs: a local port for injection and ejection, a link in the X dimension and a link in the Y dimension. A packet is one head flit, zero or more body flits and one tail flit.

The head flit names the destination node. The router resolves the X dimension first and only then the Y dimension. The output virtual channel is picked so that the wraparound link of each ring cannot close a cycle of waiting packets. A head flit that wins an output virtual channel keeps it until its tail flit has left. Packets on the two virtual channels of one physical output can interleave flit by flit. Each input virtual channel has a two-entry buffer, and flits are never dropped.

Top module: `torus_router`

## Requirements
- R1: While reset is held and just after it, no output asserts valid and every input reports ready on both virtual channels.
- R2: A head flit carries destination X in bits [3:0] and destination Y in bits [7:4]. Kind codes are 1 for head, 2 for body and 3 for tail. When destination X differs from the node's X, the packet leaves on the X output.
- R3: When destination X matches and destination Y differs, the packet leaves on the Y output.
- R4: When both coordinates match, the packet leaves on the local output with virtual channel 0.
- R5: On an output whose link does not wrap, a packet that continues in the same dimension keeps its input virtual channel. A packet that enters that dimension from another port uses virtual channel 0.
- R6: On an output whose link wraps (the node sits at coordinate K-1 in that dimension), every packet uses virtual channel 1.
- R7: Between a head flit and its tail flit, an output virtual channel carries only that packet's flits, in their original order.
- R8: When several inputs contend for one output, round-robin arbitration serves all of them, and every injected packet is delivered whole.
- R9: Each input virtual channel buffers two flits. When the path onward is blocked, its ready bit drops and no further flit is accepted.
- R10: An output asserts valid only when the downstream ready bit of the virtual channel it presents is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_in_vld | input | 1 | Local injection flit valid |
| loc_in_vc | input | 1 | Local injection virtual channel |
| loc_in_flit | input | 16 | Local injection flit data |
| loc_in_kind | input | 2 | Local injection flit kind |
| loc_in_rdy | output | 2 | Local injection ready, one bit per VC |
| xin_vld | input | 1 | X link input valid |
| xin_vc | input | 1 | X link input virtual channel |
| xin_flit | input | 16 | X link input flit data |
| xin_kind | input | 2 | X link input flit kind |
| xin_rdy | output | 2 | X link input ready per VC |
| yin_vld | input | 1 | Y link input valid |
| yin_vc | input | 1 | Y link input virtual channel |
| yin_flit | input | 16 | Y link input flit data |
| yin_kind | input | 2 | Y link input flit kind |
| yin_rdy | output | 2 | Y link input ready per VC |
| loc_out_vld | output | 1 | Ejection flit valid |
| loc_out_vc | output | 1 | Ejection virtual channel |
| loc_out_flit | output | 16 | Ejection flit data |
| loc_out_kind | output | 2 | Ejection flit kind |
| loc_out_rdy | input | 2 | Ejection sink ready per VC |
| xout_vld | output | 1 | X link output valid |
| xout_vc | output | 1 | X link output virtual channel |
| xout_flit | output | 16 | X link output flit data |
| xout_kind | output | 2 | X link output flit kind |
| xout_rdy | input | 2 | X downstream ready per VC |
| yout_vld | output | 1 | Y link output valid |
| yout_vc | output | 1 | Y link output virtual channel |
| yout_flit | output | 16 | Y link output flit data |
| yout_kind | output | 2 | Y link output flit kind |
| yout_rdy | input | 2 | Y downstream ready per VC |

## Verification
The assertions rely on the senders following the rules. Every packet must start with a head and close with a tail on a single virtual channel. A flit must stay on the wires until the ready bit of its channel is seen. Traffic arriving on the Y link must already be X-aligned, and local injection uses channel 0. The stimulus builds each packet from that template. Y-link packets always get the node's X coordinate. Packets are driven one flit at a time with a ready check before each edge, while the sinks toggle their ready bits at random to create back-pressure without breaking the handshake.

// File: rtl/torus_pkg.sv
package torus_pkg;
  localparam int FLIT_W = 16;
  localparam int NPORT  = 3;
  localparam int NVC    = 2;
  localparam int NCH    = NPORT * NVC;
  localparam int CH_W   = $clog2(NCH);

  typedef enum logic [1:0] {K_NONE = 2'd0, K_HEAD = 2'd1, K_BODY = 2'd2, K_TAIL = 2'd3} kind_t;
  typedef enum logic [1:0] {P_LOC = 2'd0, P_X = 2'd1, P_Y = 2'd2} port_t;

  typedef struct packed {
    kind_t               kind;
    logic [FLIT_W-1:0]   data;
  } flit_t;

  // First requester after 'last' in circular order; 'last' if none.
  function automatic logic [CH_W-1:0] rr_pick(input logic [NCH-1:0] req,
                                               input logic [CH_W-1:0] last);
    logic [CH_W-1:0] res;
    res = last;
    for (int k = NCH; k >= 1; k--) begin
      int i;
      i = (int'(last) + k) % NCH;
      if (req[i]) res = CH_W'(i);
    end
    return res;
  endfunction
endpackage

// File: rtl/flit_buf.sv
module flit_buf
  import torus_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  flit_t wr_flit,
  input  logic  pop,
  output flit_t head,
  output logic  not_empty,
  output logic  full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  flit_t         mem [DEPTH];
  logic [PW-1:0] wp, wp_n, rp, rp_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = cnt;
    if (push) wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
    if (pop)  rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    case ({push, pop})
      2'b10:   cnt_n = cnt + 1'b1;
      2'b01:   cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_flit;
  end

  assign head      = mem[rp];
  assign not_empty = (cnt != '0);
  assign full      = (cnt == CW'(DEPTH));

  // R7: a waiting flit does not change under the switch
  p_head_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (not_empty && !pop) |=> $stable(head));
  // R9: the switch never drains an empty buffer
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
endmodule

// File: rtl/route_unit.sv
module route_unit
  import torus_pkg::*;
#(
  parameter int K       = 4,
  parameter int NODE_X  = 1,
  parameter int NODE_Y  = 3,
  parameter int COORD_W = 4
) (
  input  port_t                  in_port,
  input  logic                   in_vc,
  input  logic [2*COORD_W-1:0]   dest,
  output port_t                  out_port,
  output logic                   out_vc
);
  localparam logic [COORD_W-1:0] MY_X = COORD_W'(NODE_X);
  localparam logic [COORD_W-1:0] MY_Y = COORD_W'(NODE_Y);
  localparam bit   X_WRAP = (NODE_X == K - 1);
  localparam bit   Y_WRAP = (NODE_Y == K - 1);

  logic [COORD_W-1:0] dx, dy;
  assign dx = dest[COORD_W-1:0];
  assign dy = dest[2*COORD_W-1:COORD_W];

  always_comb begin
    if (dx != MY_X) begin
      out_port = P_X;
      out_vc   = X_WRAP ? 1'b1 : ((in_port == P_X) ? in_vc : 1'b0);
    end else if (dy != MY_Y) begin
      out_port = P_Y;
      out_vc   = Y_WRAP ? 1'b1 : ((in_port == P_Y) ? in_vc : 1'b0);
    end else begin
      out_port = P_LOC;
      out_vc   = 1'b0;
    end
  end
endmodule

// File: rtl/torus_router.sv
module torus_router
  import torus_pkg::*;
#(
  parameter int K       = 4,
  parameter int NODE_X  = 1,
  parameter int NODE_Y  = 3,
  parameter int COORD_W = 4,
  parameter int DEPTH   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_in_vld,
  input  logic              loc_in_vc,
  input  logic [FLIT_W-1:0] loc_in_flit,
  input  logic [1:0]        loc_in_kind,
  output logic [NVC-1:0]    loc_in_rdy,
  input  logic              xin_vld,
  input  logic              xin_vc,
  input  logic [FLIT_W-1:0] xin_flit,
  input  logic [1:0]        xin_kind,
  output logic [NVC-1:0]    xin_rdy,
  input  logic              yin_vld,
  input  logic              yin_vc,
  input  logic [FLIT_W-1:0] yin_flit,
  input  logic [1:0]        yin_kind,
  output logic [NVC-1:0]    yin_rdy,
  output logic              loc_out_vld,
  output logic              loc_out_vc,
  output logic [FLIT_W-1:0] loc_out_flit,
  output logic [1:0]        loc_out_kind,
  input  logic [NVC-1:0]    loc_out_rdy,
  output logic              xout_vld,
  output logic              xout_vc,
  output logic [FLIT_W-1:0] xout_flit,
  output logic [1:0]        xout_kind,
  input  logic [NVC-1:0]    xout_rdy,
  output logic              yout_vld,
  output logic              yout_vc,
  output logic [FLIT_W-1:0] yout_flit,
  output logic [1:0]        yout_kind,
  input  logic [NVC-1:0]    yout_rdy
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // port bundling
  logic           in_vld [NPORT];
  logic           in_vc  [NPORT];
  flit_t          in_f   [NPORT];
  logic [NVC-1:0] in_rdy [NPORT];
  logic [NVC-1:0] dn_rdy [NPORT];
  logic           o_vld  [NPORT];
  logic           o_vc   [NPORT];
  flit_t          o_f    [NPORT];

  assign in_vld[P_LOC] = loc_in_vld; assign in_vc[P_LOC] = loc_in_vc;
  assign in_f[P_LOC]   = {kind_t'(loc_in_kind), loc_in_flit};
  assign in_vld[P_X]   = xin_vld;    assign in_vc[P_X]   = xin_vc;
  assign in_f[P_X]     = {kind_t'(xin_kind), xin_flit};
  assign in_vld[P_Y]   = yin_vld;    assign in_vc[P_Y]   = yin_vc;
  assign in_f[P_Y]     = {kind_t'(yin_kind), yin_flit};
  assign loc_in_rdy = in_rdy[P_LOC];
  assign xin_rdy    = in_rdy[P_X];
  assign yin_rdy    = in_rdy[P_Y];
  assign dn_rdy[P_LOC] = loc_out_rdy;
  assign dn_rdy[P_X]   = xout_rdy;
  assign dn_rdy[P_Y]   = yout_rdy;
  assign loc_out_vld = o_vld[P_LOC]; assign loc_out_vc = o_vc[P_LOC];
  assign loc_out_flit = o_f[P_LOC].data; assign loc_out_kind = o_f[P_LOC].kind;
  assign xout_vld = o_vld[P_X]; assign xout_vc = o_vc[P_X];
  assign xout_flit = o_f[P_X].data; assign xout_kind = o_f[P_X].kind;
  assign yout_vld = o_vld[P_Y]; assign yout_vc = o_vc[P_Y];
  assign yout_flit = o_f[P_Y].data; assign yout_kind = o_f[P_Y].kind;

  // input channels: channel c = port*NVC + vc
  flit_t      hd     [NCH];
  logic       hv     [NCH];
  logic       full   [NCH];
  port_t      rt_port[NCH];
  logic       rt_vc  [NCH];
  logic [NCH-1:0] pop;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int P = c / NVC;
    localparam int V = c % NVC;
    logic push;
    assign push        = in_vld[P] && (in_vc[P] == 1'(V)) && !full[c];
    assign in_rdy[P][V] = !full[c];
    flit_buf #(.DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_i), .push(push), .wr_flit(in_f[P]), .pop(pop[c]),
      .head(hd[c]), .not_empty(hv[c]), .full(full[c]));
    route_unit #(.K(K), .NODE_X(NODE_X), .NODE_Y(NODE_Y), .COORD_W(COORD_W)) u_rt (
      .in_port(port_t'(P)), .in_vc(1'(V)), .dest(hd[c].data[2*COORD_W-1:0]),
      .out_port(rt_port[c]), .out_vc(rt_vc[c]));
  end

  // output virtual-channel ownership state
  logic [NVC-1:0]  own_vld   [NPORT], own_vld_n [NPORT];
  logic [CH_W-1:0] own_ch    [NPORT][NVC], own_ch_n [NPORT][NVC];
  logic [CH_W-1:0] rr_last   [NPORT][NVC], rr_last_n[NPORT][NVC];
  logic [NPORT-1:0] sw_last, sw_last_n;
  logic [NPORT*NVC-1:0] owns [NCH];
  logic [NCH-1:0]  held;

  always_comb begin
    for (int c = 0; c < NCH; c++) owns[c] = '0;
    for (int o = 0; o < NPORT; o++)
      for (int v = 0; v < NVC; v++)
        if (own_vld[o][v]) owns[own_ch[o][v]][o*NVC+v] = 1'b1;
    for (int c = 0; c < NCH; c++) held[c] = |owns[c];
  end

  // switch traversal: per output, pick among owned VCs with data and credit
  always_comb begin
    logic [NVC-1:0] cand;
    logic           sel;
    pop       = '0;
    sw_last_n = sw_last;
    for (int o = 0; o < NPORT; o++) begin
      for (int v = 0; v < NVC; v++)
        cand[v] = own_vld[o][v] && hv[own_ch[o][v]] && dn_rdy[o][v];
      sel = (cand == 2'b11) ? ~sw_last[o] : cand[1];
      o_vld[o] = |cand;
      o_vc[o]  = sel;
      o_f[o]   = hd[own_ch[o][sel]];
      if (o_vld[o]) begin
        pop[own_ch[o][sel]] = 1'b1;
        sw_last_n[o]        = sel;
      end
    end
  end

  // VC allocation and release
  always_comb begin
    logic [NCH-1:0] reqv;
    for (int o = 0; o < NPORT; o++) begin
      own_vld_n[o] = own_vld[o];
      for (int v = 0; v < NVC; v++) begin
        own_ch_n[o][v]  = own_ch[o][v];
        rr_last_n[o][v] = rr_last[o][v];
        for (int c = 0; c < NCH; c++)
          reqv[c] = hv[c] && (hd[c].kind == K_HEAD) && !held[c] &&
                    (rt_port[c] == port_t'(o)) && (rt_vc[c] == 1'(v));
        if (own_vld[o][v]) begin
          if (o_vld[o] && (o_vc[o] == 1'(v)) && (o_f[o].kind == K_TAIL))
            own_vld_n[o][v] = 1'b0;
        end else if (|reqv) begin
          own_vld_n[o][v] = 1'b1;
          own_ch_n[o][v]  = rr_pick(reqv, rr_last[o][v]);
          rr_last_n[o][v] = rr_pick(reqv, rr_last[o][v]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sw_last <= '0;
      for (int o = 0; o < NPORT; o++) begin
        own_vld[o] <= '0;
        for (int v = 0; v < NVC; v++) begin
          own_ch[o][v]  <= '0;
          rr_last[o][v] <= CH_W'(NCH - 1);
        end
      end
    end else begin
      sw_last <= sw_last_n;
      for (int o = 0; o < NPORT; o++) begin
        own_vld[o] <= own_vld_n[o];
        for (int v = 0; v < NVC; v++) begin
          own_ch[o][v]  <= own_ch_n[o][v];
          rr_last[o][v] <= rr_last_n[o][v];
        end
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    // R10: never present a flit to a VC that cannot take it
    p_credit_r10: assert property (@(posedge clk) disable iff (!rst_i)
      o_vld[o] |-> dn_rdy[o][o_vc[o]]);
    // R7: a tail leaving releases its output VC on the next cycle
    p_tail_release_r7: assert property (@(posedge clk) disable iff (!rst_i)
      (o_vld[o] && o_f[o].kind == K_TAIL) |=> !own_vld[o][$past(o_vc[o])]);
  end
  for (genvar c = 0; c < NCH; c++) begin : g_own
    // R7: an input channel holds at most one output VC
    p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_i)
      $countones(owns[c]) <= 1);
  end
  if (NODE_Y == K - 1) begin : g_ywrap
    // R6: the wrapping Y link runs on the upper VC
    p_wrap_vc_r6: assert property (@(posedge clk) disable iff (!rst_i)
      o_vld[P_Y] |-> o_vc[P_Y]);
  end
  if (NODE_X == K - 1) begin : g_xwrap
    // R6: the wrapping X link runs on the upper VC
    p_wrap_vcx_r6: assert property (@(posedge clk) disable iff (!rst_i)
      o_vld[P_X] |-> o_vc[P_X]);
  end
endmodule

// File: tb/torus_router_test.sv
module torus_router_test;
  localparam int KK = 4;
  localparam int NX = 1;
  localparam int NY = 3;

  logic clk, rst_n;
  logic        in_vld [3];
  logic        in_vc  [3];
  logic [15:0] in_flit[3];
  logic [1:0]  in_kind[3];
  logic [1:0]  in_rdy [3];
  logic        out_vld [3];
  logic        out_vc  [3];
  logic [15:0] out_flit[3];
  logic [1:0]  out_kind[3];
  logic [1:0]  sink_rdy[3];

  int n_chk, n_fail;
  bit rnd_sink;

  bit          sent [256];
  bit          done [256];
  int          exp_port[256];
  int          exp_vc  [256];
  int          exp_len [256];
  logic [15:0] exp_head[256];

  bit   st_in [3][2];
  int   st_id [3][2];
  int   st_cnt[3][2];

  torus_router #(.K(KK), .NODE_X(NX), .NODE_Y(NY)) uut (
    .clk(clk), .rst_n(rst_n),
    .loc_in_vld(in_vld[0]), .loc_in_vc(in_vc[0]), .loc_in_flit(in_flit[0]),
    .loc_in_kind(in_kind[0]), .loc_in_rdy(in_rdy[0]),
    .xin_vld(in_vld[1]), .xin_vc(in_vc[1]), .xin_flit(in_flit[1]),
    .xin_kind(in_kind[1]), .xin_rdy(in_rdy[1]),
    .yin_vld(in_vld[2]), .yin_vc(in_vc[2]), .yin_flit(in_flit[2]),
    .yin_kind(in_kind[2]), .yin_rdy(in_rdy[2]),
    .loc_out_vld(out_vld[0]), .loc_out_vc(out_vc[0]), .loc_out_flit(out_flit[0]),
    .loc_out_kind(out_kind[0]), .loc_out_rdy(sink_rdy[0]),
    .xout_vld(out_vld[1]), .xout_vc(out_vc[1]), .xout_flit(out_flit[1]),
    .xout_kind(out_kind[1]), .xout_rdy(sink_rdy[1]),
    .yout_vld(out_vld[2]), .yout_vc(out_vc[2]), .yout_flit(out_flit[2]),
    .yout_kind(out_kind[2]), .yout_rdy(sink_rdy[2]));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // expected output port per R2/R3/R4 and VC per R4/R5/R6
  function automatic int model_port(input int dx, input int dy);
    if (dx != NX) return 1;
    if (dy != NY) return 2;
    return 0;
  endfunction
  function automatic int model_vc(input int inp, input int ivc, input int dx, input int dy);
    int op;
    op = model_port(dx, dy);
    if (op == 0) return 0;
    if (op == 1) return (NX == KK - 1) ? 1 : ((inp == 1) ? ivc : 0);
    return (NY == KK - 1) ? 1 : ((inp == 2) ? ivc : 0);
  endfunction
  function automatic string port_req(input int o);
    return (o == 0) ? "R4" : ((o == 1) ? "R2" : "R3");
  endfunction
  function automatic string vc_req(input int o);
    if (o == 2) return (NY == KK - 1) ? "R6" : "R5";
    if (o == 1) return (NX == KK - 1) ? "R6" : "R5";
    return "R4";
  endfunction

  task automatic send_pkt(input int p, input int vc, input int id,
                          input int dx, input int dy, input int nbody);
    logic [15:0] h;
    h = {8'(id), 4'(dy), 4'(dx)};
    exp_port[id] = model_port(dx, dy);
    exp_vc[id]   = model_vc(p, vc, dx, dy);
    exp_len[id]  = nbody + 2;
    exp_head[id] = h;
    sent[id]     = 1'b1;
    for (int i = 0; i < nbody + 2; i++) begin
      @(negedge clk);
      in_vld[p]  = 1'b1;
      in_vc[p]   = 1'(vc);
      in_kind[p] = (i == 0) ? 2'd1 : ((i == nbody + 1) ? 2'd3 : 2'd2);
      in_flit[p] = (i == 0) ? h : {8'(id), 8'(i)};
      while (!in_rdy[p][vc]) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_vld[p] = 1'b0;
  endtask

  task automatic wait_done(input int id);
    while (!done[id]) @(negedge clk);
  endtask

  // monitor: reassemble packets per output VC
  always @(negedge clk) begin
    #1;
    for (int o = 0; o < 3; o++) begin
      if (rst_n && out_vld[o] && sink_rdy[o][out_vc[o]]) begin
        int v;
        v = int'(out_vc[o]);
        if (out_kind[o] == 2'd1) begin
          int id;
          id = int'(out_flit[o][15:8]);
          chk(!st_in[o][v], "R7", "head inside open packet", 1, 0);
          chk(sent[id] && !done[id], "R8", "unexpected packet id", id, id);
          chk(exp_port[id] == o, port_req(o), "output port", o, exp_port[id]);
          chk(exp_vc[id] == v, vc_req(o), "output vc", v, exp_vc[id]);
          chk(out_flit[o] == exp_head[id], "R7", "head flit", int'(out_flit[o]), int'(exp_head[id]));
          st_in[o][v]  = 1'b1;
          st_id[o][v]  = id;
          st_cnt[o][v] = 1;
        end else begin
          chk(st_in[o][v], "R7", "body outside packet", 0, 1);
          chk(out_flit[o] == {8'(st_id[o][v]), 8'(st_cnt[o][v])}, "R7", "body flit order",
              int'(out_flit[o]), int'({8'(st_id[o][v]), 8'(st_cnt[o][v])}));
          st_cnt[o][v]++;
          if (out_kind[o] == 2'd3) begin
            chk(st_cnt[o][v] == exp_len[st_id[o][v]], "R7", "packet length",
                st_cnt[o][v], exp_len[st_id[o][v]]);
            done[st_id[o][v]] = 1'b1;
            st_in[o][v] = 1'b0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rnd_sink)
      for (int o = 0; o < 3; o++) sink_rdy[o] = 2'($urandom_range(0, 3));
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int id;
    void'($urandom(32'd20240611));
    n_chk = 0;
    n_fail = 0;
    rnd_sink = 1'b0;
    rst_n = 1'b0;
    for (int p = 0; p < 3; p++) begin
      in_vld[p] = 1'b0; in_vc[p] = 1'b0; in_flit[p] = '0; in_kind[p] = '0;
      sink_rdy[p] = 2'b11;
    end
    repeat (3) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      chk(out_vld[p] == 1'b0, "R1", "valid in reset", int'(out_vld[p]), 0);
      chk(in_rdy[p] == 2'b11, "R1", "ready in reset", int'(in_rdy[p]), 3);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int p = 0; p < 3; p++)
      chk(in_rdy[p] == 2'b11 && !out_vld[p], "R1", "idle after reset", int'(in_rdy[p]), 3);

    // directed routes: R4 local, R2 X, R5 VC keep, R3/R6 Y wrap
    send_pkt(0, 0, 1, NX, NY, 2);  wait_done(1);
    send_pkt(0, 0, 2, 2, 3, 1);    wait_done(2);
    send_pkt(1, 1, 3, 0, 0, 3);    wait_done(3);
    send_pkt(1, 0, 4, 3, 2, 0);    wait_done(4);
    send_pkt(1, 0, 5, NX, 0, 2);   wait_done(5);
    send_pkt(2, 0, 6, NX, 1, 1);   wait_done(6);
    send_pkt(2, 1, 7, NX, NY, 4);  wait_done(7);

    // R8: three inputs contend for the local output
    fork
      send_pkt(0, 0, 10, NX, NY, 5);
      send_pkt(1, 1, 11, NX, NY, 5);
      send_pkt(2, 0, 12, NX, NY, 5);
    join
    wait_done(10); wait_done(11); wait_done(12);

    // R9/R10: blocked Y output fills the local buffer
    sink_rdy[2] = 2'b00;
    fork
      send_pkt(0, 0, 20, NX, 0, 6);
    join_none
    repeat (20) @(negedge clk);
    #2;
    chk(in_rdy[0][0] == 1'b0, "R9", "local ready while blocked", int'(in_rdy[0][0]), 0);
    chk(out_vld[2] == 1'b0, "R10", "valid without credit", int'(out_vld[2]), 0);
    chk(!done[20], "R9", "packet passed blocked link", int'(done[20]), 0);
    @(negedge clk);
    sink_rdy[2] = 2'b11;
    wait_done(20);

    // random traffic with random back-pressure
    rnd_sink = 1'b1;
    id = 30;
    for (int b = 0; b < 60; b++) begin
      fork
        send_pkt(0, 0, id, $urandom_range(0, KK-1), $urandom_range(0, KK-1), $urandom_range(0, 4));
        send_pkt(1, $urandom_range(0, 1), id + 1, $urandom_range(0, KK-1),
                 $urandom_range(0, KK-1), $urandom_range(0, 4));
        send_pkt(2, $urandom_range(0, 1), id + 2, NX, $urandom_range(0, KK-1), $urandom_range(0, 4));
      join
      id += 3;
    end
    for (int k = 30; k < id; k++) wait_done(k);
    rnd_sink = 1'b0;
    repeat (5) @(negedge clk);

    begin
      int lost;
      lost = 0;
      for (int k = 0; k < 256; k++) if (sent[k] && !done[k]) lost++;
      chk(lost == 0, "R8", "packets not delivered", lost, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule